// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block watches a single service line that running software has to toggle regularly. Either a rising or a falling transition counts as a valid service. When the line holds one level, high or low, for a full time-out window, the block raises a reset request. The request stays up for a fixed number of cycles and then the block re-arms itself with a fresh, full window.

The block drives the chip's reset sequencer. The sequencer combines this request with its other fault sources and reports back, on a separate input, whenever any system reset is in force. While that input is high the idle counter stays cleared, so a new window starts only after the system leaves reset.

The time-out window and the request length are parameters in clock cycles. The service line is asynchronous and passes through a two-flop synchronizer before edge detection.

Top module: `wdog_edge_monitor`

## Requirements
- R1: In reset and in the first cycle after it, `rst_req` and `timeout_pulse` are both 0.
- R2: A rising transition of `kick_in` clears the idle count, so a line that rises at least once per window never causes a time-out.
- R3: A falling transition of `kick_in` clears the idle count in the same way as a rising one.
- R4: If no transition is detected for `TIMEOUT_CYC` consecutive cycles, a time-out occurs. This applies whether the line rests high or low.
- R5: After a time-out, `rst_req` is 1 for exactly `PULSE_CYC` consecutive cycles and then returns to 0.
- R6: `timeout_pulse` is 1 for exactly one cycle per time-out, in the first cycle that `rst_req` is 1.
- R7: While `sys_rst_active` is 1 the idle count is held at zero and no time-out occurs. After release, a full `TIMEOUT_CYC` window applies.
- R8: Transitions on `kick_in` while `rst_req` is 1 are ignored. They neither shorten the request nor retrigger it. When the request ends, a full window starts again.
- R9: `kick_in` is sampled through two synchronizer flops and then compared with its previous synchronized value. If `kick_in` last changes before clock edge j, `rst_req` first reads 1 after edge j+`TIMEOUT_CYC`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick_in | input | 1 | Asynchronous service line; any transition services the watchdog |
| sys_rst_active | input | 1 | High while any system reset is in force; holds the idle count cleared |
| rst_req | output | 1 | Level reset request, `PULSE_CYC` cycles long per time-out |
| timeout_pulse | output | 1 | One-cycle strobe marking each time-out |

## Verification
The line is driven with four patterns, and each one separates a different fault:
- A single rise followed by a long high, and a single fall followed by a long low, show whether each polarity clears the count on its own.
- Steady toggling faster than the window must never fire. Holding the line high and then low must fire again each window after re-arming.
- Toggling every cycle during a request checks that the request is neither cut short nor extended.
- Holding the system-reset input across more than one window shows the count is frozen and restarts fully.

A directed sample on either side of the expected rising cycle pins down the exact synchronizer latency.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        WD_ARMED  = 1'b0,
        WD_FIRING = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic level;
        logic toggled;
    } kick_info_t;

    function automatic int unsigned ctr_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/wdog_kick_sync.sv
module wdog_kick_sync
    import wdog_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kick_raw,
    output kick_info_t info
);

    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              last_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain      <= '0;
            last_level <= 1'b0;
        end else begin
            chain[0]   <= kick_raw;
            last_level <= chain[TOP];
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_comb begin
        info.level   = chain[TOP];
        info.toggled = chain[TOP] ^ last_level;
    end

    // R9: a detected transition means the synchronized level moved
    p_toggle_moves_level_r9: assert property (@(posedge clk) disable iff (rst)
        info.toggled |=> (last_level != $past(last_level)));

endmodule

// File: rtl/wdog_idle_counter.sv
module wdog_idle_counter
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1_100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic toggled,
    output logic fire
);

    localparam int unsigned CW = ctr_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] idle_cnt;
    logic          at_limit;

    assign at_limit = (idle_cnt == LAST);
    assign fire     = !hold && !toggled && at_limit;

    always_ff @(posedge clk) begin
        if (rst || hold || toggled || fire) idle_cnt <= '0;
        else                                idle_cnt <= idle_cnt + 1'b1;
    end

    // R4: count never passes the window limit
    p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (rst)
        idle_cnt <= LAST);
    // R7: a held cycle leaves the count at zero
    p_hold_clears_r7: assert property (@(posedge clk) disable iff (rst)
        hold |=> (idle_cnt == '0));
    // R2: a detected transition restarts the window
    p_toggle_clears_r2: assert property (@(posedge clk) disable iff (rst)
        toggled |=> (idle_cnt == '0));

endmodule

// File: rtl/wdog_pulse_stretch.sv
module wdog_pulse_stretch
    import wdog_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 130_000
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic req,
    output logic strobe
);

    localparam int unsigned PW = ctr_width(PULSE_CYC);
    localparam logic [PW-1:0] PLAST = PW'(PULSE_CYC - 1);

    wd_state_e     state;
    logic [PW-1:0] held_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WD_ARMED;
            held_cnt <= '0;
            strobe   <= 1'b0;
        end else begin
            strobe <= 1'b0;
            unique case (state)
                WD_ARMED: begin
                    held_cnt <= '0;
                    if (fire) begin
                        state  <= WD_FIRING;
                        strobe <= 1'b1;
                    end
                end
                WD_FIRING: begin
                    if (held_cnt == PLAST) begin
                        state    <= WD_ARMED;
                        held_cnt <= '0;
                    end else begin
                        held_cnt <= held_cnt + 1'b1;
                    end
                end
                default: state <= WD_ARMED;
            endcase
        end
    end

    assign req = (state == WD_FIRING);

    // R5: held count stays inside the request length
    p_len_bound_r5: assert property (@(posedge clk) disable iff (rst)
        held_cnt <= PLAST);
    // R6: strobe lasts a single cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
    // R6: request starts together with the strobe
    p_rise_with_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> strobe);

endmodule

// File: rtl/wdog_edge_monitor.sv
module wdog_edge_monitor
    import wdog_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1_100_000,
    parameter int unsigned PULSE_CYC   = 130_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_in,
    input  logic sys_rst_active,
    output logic rst_req,
    output logic timeout_pulse
);

    kick_info_t kick_info;
    logic       hold;
    logic       fire;

    wdog_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .kick_raw (kick_in),
        .info     (kick_info)
    );

    assign hold = sys_rst_active | rst_req;

    wdog_idle_counter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_idle (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .toggled (kick_info.toggled),
        .fire    (fire)
    );

    wdog_pulse_stretch #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (fire),
        .req    (rst_req),
        .strobe (timeout_pulse)
    );

    // R8: no second strobe while a request is already running
    p_no_refire_r8: assert property (@(posedge clk) disable iff (rst)
        (rst_req && $past(rst_req)) |-> !timeout_pulse);
    // R7: system reset input blocks new time-outs
    p_sys_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_active && !rst_req) |=> !timeout_pulse);

endmodule

// File: tb/wdog_edge_monitor_tb.sv
module wdog_edge_monitor_tb_top;

    localparam int T = 20;
    localparam int P = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic kick_in = 1'b0;
    logic sys_rst_active = 1'b0;
    logic rst_req;
    logic timeout_pulse;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    wdog_edge_monitor #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .SYNC_STAGES(2)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .kick_in        (kick_in),
        .sys_rst_active (sys_rst_active),
        .rst_req        (rst_req),
        .timeout_pulse  (timeout_pulse)
    );

    // behavioural reference
    bit hist[$] = '{0, 0, 0};
    int m_idle = 0;
    int m_left = 0;
    bit m_req = 0;
    bit m_strobe = 0;
    bit m_saw_edge, m_held, m_fire;

    always @(posedge clk) begin
        m_saw_edge = (hist[1] != hist[2]);
        m_held     = rst || sys_rst_active || m_req;
        m_fire     = !m_held && !m_saw_edge && (m_idle == T - 1);
        if (m_held || m_saw_edge || m_fire) m_idle = 0;
        else m_idle = m_idle + 1;
        if (rst) begin
            m_req = 0; m_left = 0;
        end else if (m_req) begin
            m_left = m_left - 1;
            if (m_left == 0) m_req = 0;
        end else if (m_fire) begin
            m_req = 1; m_left = P;
        end
        m_strobe = !rst && m_fire;
        hist.push_front(rst ? 1'b0 : kick_in);
        void'(hist.pop_back());
        cycles++;
    end

    // compare every cycle, away from the active edge
    int run_len = 0;
    always @(negedge clk) begin
        checks++;
        if (rst_req !== m_req || timeout_pulse !== m_strobe) begin
            fails++;
            $display("FAIL %s cycle %0d: rst_req=%0b exp %0b, timeout_pulse=%0b exp %0b",
                     phase, cycles, rst_req, m_req, timeout_pulse, m_strobe);
        end
        if (rst_req === 1'b1) run_len++;
        else if (run_len > 0) begin
            checks++;
            if (run_len != P) begin
                fails++;
                $display("FAIL R5 request length %0d exp %0d", run_len, P);
            end
            run_len = 0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_req(input bit exp, input string tag);
        checks++;
        if (rst_req !== exp) begin
            fails++;
            $display("FAIL %s rst_req=%0b exp %0b", tag, rst_req, exp);
        end
    endtask

    initial begin
        cyc(3);
        checks++;
        if (rst_req !== 1'b0 || timeout_pulse !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs %0b%0b exp 00", rst_req, timeout_pulse);
        end
        rst = 1'b0;
        cyc(2);

        phase = "R2";
        cyc(10); kick_in = 1'b1; cyc(17);
        phase = "R3";
        kick_in = 1'b0; cyc(17);
        phase = "R2";
        for (int i = 0; i < 8; i++) begin
            kick_in = ~kick_in; cyc(12);
        end

        phase = "R9";
        kick_in = ~kick_in;
        cyc(T + 2); expect_req(1'b0, "R9 before latency");
        cyc(1);     expect_req(1'b1, "R9 at latency");
        cyc(P + 2);

        phase = "R4";
        kick_in = 1'b0; cyc(60);
        kick_in = 1'b1; cyc(60);

        phase = "R8";
        while (rst_req !== 1'b1) cyc(1);
        for (int i = 0; i < 5; i++) begin
            kick_in = ~kick_in; cyc(1);
        end
        cyc(40);

        phase = "R7";
        while (rst_req === 1'b1) cyc(1);
        sys_rst_active = 1'b1; cyc(3 * T);
        sys_rst_active = 1'b0; cyc(T + 2 * P);

        phase = "R6";
        kick_in = ~kick_in; cyc(2 * T);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule